// File: doc/BRIEF.md
# Self-Clocked Bitstream Half-Sum Adder

This block adds two single-bit pulse-density streams and produces one stream whose density of ones is half the sum of the input densities. The same logic works for unipolar and bipolar encodings, because the scale factor of one half applies to both. When the two input bits agree, the common bit goes straight to the output. When they disagree, exactly one of them has to be represented, and an internal toggle flip-flop decides which: it supplies the output bit and then flips. Successive disagreements are therefore shared out alternately. No pseudo-random source is involved.

No input bit is dropped without being accounted for. The toggle carries at most half a unit of pending value from one cycle to the next, so it acts as the one-sample memory that keeps the first-order noise shaping of delta-sigma modulated inputs. An enable input lets the block sit in a stream that advances only on selected cycles. The output is combinational from the inputs and the current toggle state.

Top module: `tff_stream_adder`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the toggle state to 0. Right after reset, the differing input pair x_bit=1, y_bit=0 yields z_bit=0.
- R2: Whenever x_bit equals y_bit, z_bit equals that common value in the same cycle, whatever the state of en.
- R3: A clock edge with en high and equal input bits leaves the toggle state unchanged.
- R4: Whenever x_bit differs from y_bit, z_bit equals the current toggle state.
- R5: A clock edge with en high and differing input bits inverts the toggle state.
- R6: A clock edge with en low leaves the toggle state unchanged, whatever the input bits are.
- R7: Count over the enabled cycles since the last reset. Twice the number of output ones, minus the number of input ones on both inputs together, is always 0 or -1. So over any window, the output ones count differs from half the input ones count by at most one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the toggle state when high |
| x_bit | input | 1 | First input stream bit |
| y_bit | input | 1 | Second input stream bit |
| z_bit | output | 1 | Half-sum output stream bit |

## Verification
Long runs of equal pairs, both all zeros and all ones, show that agreement passes straight through and never moves the toggle. Back-to-back disagreements in both polarities (1/0 and 0/1) show strict alternation, which separates a correct flip from a stuck or inverted state. Pseudo-random pairs, with enable gaps and a reset in the middle, exercise every mix of cases. Throughout these runs the bench tracks the running ones balance, so any lost or duplicated bit is caught even where the single-cycle checks would agree by chance.

// File: rtl/tff_stream_adder.sv
module tff_stream_adder (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic x_bit,
  input  logic y_bit,
  output logic z_bit
);

  logic tgl;
  logic split;

  assign split = x_bit ^ y_bit;
  assign z_bit = split ? tgl : x_bit;

  always_ff @(posedge clk) begin
    if (rst)
      tgl <= 1'b0;
    else if (en && split)
      tgl <= ~tgl;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !tgl);

  assert_equal_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (x_bit == y_bit) |-> (z_bit == x_bit));

  assert_equal_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (en && x_bit == y_bit) |=> (tgl == $past(tgl)));

  assert_split_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (en && x_bit != y_bit) |=> (tgl != $past(tgl)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(tgl));

  logic signed [3:0] bal;
  always_ff @(posedge clk) begin
    if (rst)
      bal <= 4'sd0;
    else if (en)
      bal <= bal + (z_bit ? 4'sd2 : 4'sd0) - (x_bit ? 4'sd1 : 4'sd0) - (y_bit ? 4'sd1 : 4'sd0);
  end

  assert_balance_R7: assert property (@(posedge clk) disable iff (rst)
    (bal == 4'sd0) || (bal == -4'sd1));

endmodule

// File: tb/tb_tff_stream_adder.sv
`timescale 1ns/1ps
module tb_tff_stream_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic xa = 1'b0;
  logic yb = 1'b0;
  logic z;

  int checks = 0;
  int errors = 0;
  bit m_t = 1'b0;
  int in_ones = 0;
  int out_ones = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tff_stream_adder dut (.clk(clk), .rst(rst), .en(en), .x_bit(xa), .y_bit(yb), .z_bit(z));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit e, input bit a, input bit b, input string tag);
    bit expz;
    bit seen;
    @(negedge clk);
    rst = r; en = e; xa = a; yb = b;
    #1;
    seen = z;
    expz = (a == b) ? a : m_t;
    if (!r) check(seen === expz, tag, seen, expz);
    @(posedge clk);
    if (r) begin
      m_t = 1'b0; in_ones = 0; out_ones = 0;
    end else if (e) begin
      in_ones += a + b;
      out_ones += seen;
      if (a != b) m_t = ~m_t;
      check((2*out_ones - in_ones == 0) || (2*out_ones - in_ones == -1),
            "R7 balance", 2*out_ones - in_ones, 0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, "reset");
    step(1, 0, 0, 0, "reset");
    step(0, 0, 1, 0, "R1 state 0 after reset");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, "R2 R3 zeros pass");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 1, "R2 R3 ones pass");
    step(0, 1, 1, 0, "R4 state unchanged by equal pairs");
    for (int i = 0; i < 8; i++) step(0, 1, i[0], ~i[0], "R4 R5 alternation");
    step(0, 0, 1, 0, "R6 sample before idle");
    for (int i = 0; i < 5; i++) step(0, 0, i[0], ~i[0], "R6 idle hold");
    step(0, 0, 0, 0, "R2 equal pass with en low");
    step(0, 0, 1, 1, "R2 equal pass with en low");
    step(0, 1, 0, 1, "R6 state kept across idle");
    step(0, 1, 0, 1, "R5 flip after idle");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, lfsr[3] | lfsr[7], lfsr[0], lfsr[5], "R2 R4 R7 random mix");
    end
    step(0, 1, 1, 0, "R5 before midstream reset");
    step(1, 1, 1, 0, "reset");
    step(0, 1, 1, 0, "R1 midstream reset clears state");
    step(0, 1, 1, 0, "R5 flip after reset");
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, 1, lfsr[2], lfsr[9], "R7 random enabled");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule